// File: doc/BRIEF.md
# Extended Subword Load/Store Converter

This block sits between the data memory and a media register file that keeps each byte in a widened 12-bit lane. A load takes one 64-bit memory word of eight bytes and spreads it into a 96-bit register image of eight 12-bit lanes. Each byte is widened either by padding with zeros or by copying its sign bit, depending on the opcode. A store takes a 96-bit register image and packs it into a 64-bit memory word. Each 12-bit lane is read as a signed value and clamped into either the unsigned or the signed byte range.

Lane arithmetic elsewhere in the datapath never saturates. Clamping therefore happens only on the way to memory. Software needs no separate pack, unpack or saturate step around a load or a store. The result is registered. It appears one cycle after the request, together with a registered valid flag and a copy of the opcode. Address generation, caching and the register file itself are outside this block.

Top module: `xsw_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, `out_valid` is 0, and `out_op`, `reg_rdata` and `mem_wdata` are all zero.
- R2: Opcode 2'b00 (zero-extending load): lane i of `reg_rdata`, at bits [12i+11:12i], holds byte i of `mem_rdata`, at bits [8i+7:8i], with its upper four bits zero.
- R3: Opcode 2'b01 (sign-extending load): lane i holds byte i, with its upper four bits all equal to bit 7 of that byte.
- R4: Opcode 2'b10 (store to unsigned bytes): each lane, read as a signed 12-bit value, becomes byte i of `mem_wdata`. Negative values become 8'h00, values above 255 become 8'hFF, and values from 0 to 255 pass through unchanged.
- R5: Opcode 2'b11 (store to signed bytes): values below -128 become 8'h80, values above 127 become 8'h7F, and values from -128 to 127 become their two's-complement low byte.
- R6: `out_valid` equals `in_valid` from the previous clock edge. The results of an accepted request are visible in the same cycle that `out_valid` is high.
- R7: A load (opcode bit 1 clear) changes only `reg_rdata`, and `mem_wdata` keeps its value. A store changes only `mem_wdata`, and `reg_rdata` keeps its value. When `in_valid` is low, both data outputs and `out_op` keep their values, whatever appears on the data inputs.
- R8: `out_op` holds the opcode of the most recently accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; the opcode and data are taken on this edge |
| in_op | input | 2 | Bit 1: store (1) or load (0). Bit 0: signed variant |
| mem_rdata | input | 64 | Packed memory word for loads, eight bytes |
| reg_wdata | input | 96 | Register image for stores, eight 12-bit lanes |
| out_valid | output | 1 | Registered request strobe |
| out_op | output | 2 | Opcode of the last accepted request |
| reg_rdata | output | 96 | Widened load result |
| mem_wdata | output | 64 | Clamped store result |

## Verification
The bench builds the block with its default parameters: eight lanes, 8-bit memory elements and 12-bit register lanes. With these widths a single register image can reach the full signed lane range from -2048 to 2047. The bench therefore places both clamp edges of each store mode (-129/-128, 127/128, -1/0, 255/256) and both lane extremes next to each other in one request. Byte patterns whose top bit alternates from lane to lane show whether each lane is extended independently and lands in the right position.

// File: rtl/xsw_pkg.sv
package xsw_pkg;

   typedef enum logic [1:0] {
      XSW_LD_ZX = 2'b00,
      XSW_LD_SX = 2'b01,
      XSW_ST_UB = 2'b10,
      XSW_ST_SB = 2'b11
   } xsw_op_e;

   function automatic logic xsw_is_store(input logic [1:0] op);
      return op[1];
   endfunction

   function automatic logic xsw_is_signed(input logic [1:0] op);
      return op[0];
   endfunction

endpackage

// File: rtl/xsw_widen.sv
module xsw_widen #(
   parameter int LANES  = 8,
   parameter int NARROW = 8,
   parameter int WIDE   = 12
) (
   input  logic                    sext,
   input  logic [LANES*NARROW-1:0] packed_in,
   output logic [LANES*WIDE-1:0]   wide_out
);
   localparam int PAD = WIDE - NARROW;

   if (PAD < 1) begin : g_bad_pad
      $error("xsw_widen: WIDE must exceed NARROW");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [NARROW-1:0] elem;
      logic              fill;
      assign elem = packed_in[i*NARROW +: NARROW];
      assign fill = sext & elem[NARROW-1];
      assign wide_out[i*WIDE +: WIDE] = {{PAD{fill}}, elem};
   end
endmodule

// File: rtl/xsw_sat_lane.sv
module xsw_sat_lane #(
   parameter int NARROW = 8,
   parameter int WIDE   = 12
) (
   input  logic [WIDE-1:0]   lane_in,
   input  logic              to_signed,
   output logic [NARROW-1:0] byte_out
);
   localparam int UMAX_I = (1 << NARROW) - 1;
   localparam int SMAX_I = (1 << (NARROW - 1)) - 1;
   localparam int SMIN_I = -(1 << (NARROW - 1));
   localparam logic signed [WIDE-1:0] K_UMAX = WIDE'(UMAX_I);
   localparam logic signed [WIDE-1:0] K_SMAX = WIDE'(SMAX_I);
   localparam logic signed [WIDE-1:0] K_SMIN = WIDE'(SMIN_I);
   localparam logic [NARROW-1:0] B_SMAX = {1'b0, {(NARROW-1){1'b1}}};
   localparam logic [NARROW-1:0] B_SMIN = {1'b1, {(NARROW-1){1'b0}}};

   if (WIDE <= NARROW) begin : g_bad_width
      $error("xsw_sat_lane: WIDE must exceed NARROW");
   end

   logic signed [WIDE-1:0] val;
   assign val = $signed(lane_in);

   always_comb begin
      if (!to_signed) begin
         if (val < 0)            byte_out = '0;
         else if (val > K_UMAX)  byte_out = '1;
         else                    byte_out = lane_in[NARROW-1:0];
      end else begin
         if (val < K_SMIN)       byte_out = B_SMIN;
         else if (val > K_SMAX)  byte_out = B_SMAX;
         else                    byte_out = lane_in[NARROW-1:0];
      end
   end

   // R4/R5: an in-range lane must keep its low byte unchanged
   always_comb begin
      if (!to_signed && val >= 0 && val <= K_UMAX)
         a_r4_pass_through: assert (byte_out == lane_in[NARROW-1:0]);
      if (to_signed && val >= K_SMIN && val <= K_SMAX)
         a_r5_pass_through: assert (byte_out == lane_in[NARROW-1:0]);
   end
endmodule

// File: rtl/xsw_narrow.sv
module xsw_narrow #(
   parameter int LANES  = 8,
   parameter int NARROW = 8,
   parameter int WIDE   = 12
) (
   input  logic                    to_signed,
   input  logic [LANES*WIDE-1:0]   wide_in,
   output logic [LANES*NARROW-1:0] packed_out
);
   if (LANES < 1) begin : g_bad_lanes
      $error("xsw_narrow: LANES must be positive");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      xsw_sat_lane #(
         .NARROW (NARROW),
         .WIDE   (WIDE)
      ) u_sat (
         .lane_in   (wide_in[i*WIDE +: WIDE]),
         .to_signed (to_signed),
         .byte_out  (packed_out[i*NARROW +: NARROW])
      );
   end
endmodule

// File: rtl/xsw_unit.sv
module xsw_unit #(
   parameter int LANES  = 8,
   parameter int NARROW = 8,
   parameter int WIDE   = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [1:0]              in_op,
   input  logic [LANES*NARROW-1:0] mem_rdata,
   input  logic [LANES*WIDE-1:0]   reg_wdata,
   output logic                    out_valid,
   output logic [1:0]              out_op,
   output logic [LANES*WIDE-1:0]   reg_rdata,
   output logic [LANES*NARROW-1:0] mem_wdata
);
   import xsw_pkg::*;

   localparam int MW = LANES * NARROW;
   localparam int RW = LANES * WIDE;

   if (NARROW < 2) begin : g_bad_narrow
      $error("xsw_unit: NARROW must be at least 2");
   end

   logic [RW-1:0] widened;
   logic [MW-1:0] narrowed;
   logic          is_store;
   logic          is_signed;

   assign is_store  = xsw_is_store(in_op);
   assign is_signed = xsw_is_signed(in_op);

   xsw_widen #(.LANES(LANES), .NARROW(NARROW), .WIDE(WIDE)) u_widen (
      .sext      (is_signed),
      .packed_in (mem_rdata),
      .wide_out  (widened)
   );

   xsw_narrow #(.LANES(LANES), .NARROW(NARROW), .WIDE(WIDE)) u_narrow (
      .to_signed  (is_signed),
      .wide_in    (reg_wdata),
      .packed_out (narrowed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_op    <= '0;
         reg_rdata <= '0;
         mem_wdata <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_op <= in_op;
            if (is_store) mem_wdata <= narrowed;
            else          reg_rdata <= widened;
         end
      end
   end

   // R6: the valid flag follows the request by exactly one edge
   a_r6_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r6_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R7: idle cycles and the other path leave results untouched
   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(reg_rdata) && $stable(mem_wdata) && $stable(out_op)));
   a_r7_load_keeps_store: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_op[1]) |=> $stable(mem_wdata));
   a_r7_store_keeps_load: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op[1]) |=> $stable(reg_rdata));

   // R8: the opcode is echoed with its result
   a_r8_op_echo: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_op == $past(in_op)));

   for (genvar i = 0; i < LANES; i++) begin : g_chk
      // R2: zero-extended lanes carry no set bits above the byte
      a_r2_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_op == XSW_LD_ZX) |=>
            (reg_rdata[i*WIDE+NARROW +: WIDE-NARROW] == '0));
      // R3: sign-extended lanes have a uniform top including the byte's msb
      a_r3_sign_top: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_op == XSW_LD_SX) |=>
            ($countones(reg_rdata[i*WIDE+NARROW-1 +: WIDE-NARROW+1]) == 0 ||
             $countones(reg_rdata[i*WIDE+NARROW-1 +: WIDE-NARROW+1]) == WIDE-NARROW+1));
      // R4: negative lanes clamp to zero on an unsigned store
      a_r4_neg_floor: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_op == XSW_ST_UB && reg_wdata[i*WIDE+WIDE-1]) |=>
            (mem_wdata[i*NARROW +: NARROW] == '0));
      // R5: the signed store result keeps the sign of a negative lane
      a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_op == XSW_ST_SB) |=>
            (mem_wdata[i*NARROW+NARROW-1] == $past(reg_wdata[i*WIDE+WIDE-1])));
   end
endmodule

// File: tb/xsw_unit_bench.sv
module xsw_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_op = 2'b00;
   logic [63:0] mem_rdata = '0;
   logic [95:0] reg_wdata = '0;
   logic        out_valid;
   logic [1:0]  out_op;
   logic [95:0] reg_rdata;
   logic [63:0] mem_wdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [95:0] exp_reg = '0;
   logic [63:0] exp_mem = '0;
   logic [1:0]  exp_op  = '0;

   always #4 clk = ~clk;  // 125 MHz

   xsw_unit u_xsw_unit (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_op (in_op),
      .mem_rdata (mem_rdata), .reg_wdata (reg_wdata),
      .out_valid (out_valid), .out_op (out_op),
      .reg_rdata (reg_rdata), .mem_wdata (mem_wdata)
   );

   localparam int NV = 8;
   localparam logic [1:0] T_OP [NV] = '{2'b00, 2'b01, 2'b10, 2'b11,
                                        2'b01, 2'b10, 2'b00, 2'b11};
   localparam logic [63:0] T_MEM [NV] = '{
      64'h807FFF0001FE8110, 64'h807FFF0001FE8110, 64'hDEADBEEF01234567,
      64'h0, 64'hFFFFFFFFFFFFFFFF, 64'h55AA55AA55AA55AA,
      64'h0123456789ABCDEF, 64'h7F80817E00FF0102};
   localparam logic [95:0] T_REG [NV] = '{
      96'h0, 96'h123456789ABCDEF012345678,
      96'h0010807FF1000FF000FFF800, 96'h0010807FF1000FF000FFF800,
      96'h0, 96'hF7FF80F81F7E07F0800FF100,
      96'hFFFFFFFFFFFFFFFFFFFFFFFF, 96'hF7FF80F81F7E07F0800FF100};

   function automatic logic [95:0] m_widen(input logic [63:0] m, input bit sx);
      logic [95:0] w;
      for (int i = 0; i < 8; i++) begin
         logic [7:0] b;
         b = m[8*i +: 8];
         w[12*i +: 12] = {{4{sx & b[7]}}, b};
      end
      return w;
   endfunction

   function automatic logic [63:0] m_narrow(input logic [95:0] r, input bit sg);
      logic [63:0] p;
      for (int i = 0; i < 8; i++) begin
         int v;
         v = int'($signed(r[12*i +: 12]));
         if (!sg) v = (v < 0) ? 0 : (v > 255) ? 255 : v;
         else     v = (v < -128) ? -128 : (v > 127) ? 127 : v;
         p[8*i +: 8] = v[7:0];
      end
      return p;
   endfunction

   task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] op, input logic [63:0] m, input logic [95:0] r);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; mem_rdata = m; reg_wdata = r;
      @(negedge clk);
      in_valid = 1'b0;
      exp_op = op;
      if (op[1]) exp_mem = m_narrow(r, op[0]);
      else       exp_reg = m_widen(m, op[0]);
      chk("R6 out_valid", {95'd0, out_valid}, 96'd1);
      chk("R8 out_op", {94'd0, out_op}, {94'd0, exp_op});
      if (op[1]) begin
         chk(op[0] ? "R5 signed store" : "R4 unsigned store", {32'd0, mem_wdata}, {32'd0, exp_mem});
         chk("R7 store keeps reg_rdata", reg_rdata, exp_reg);
      end else begin
         chk(op[0] ? "R3 sign load" : "R2 zero load", reg_rdata, exp_reg);
         chk("R7 load keeps mem_wdata", {32'd0, mem_wdata}, {32'd0, exp_mem});
      end
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 out_valid", {95'd0, out_valid}, 96'd0);
      chk("R1 reg_rdata", reg_rdata, 96'd0);
      chk("R1 mem_wdata", {32'd0, mem_wdata}, 96'd0);
      chk("R1 out_op", {94'd0, out_op}, 96'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {95'd0, out_valid}, 96'd0);

      for (int k = 0; k < NV; k++) run_op(T_OP[k], T_MEM[k], T_REG[k]);

      // R2/R3 hand-worked corner patterns with alternating msb
      run_op(2'b00, 64'h807FFF0001FE8110, '0);
      chk("R2 literal", reg_rdata, 96'h08007F0FF0000010FE081010);
      run_op(2'b01, 64'h807FFF0001FE8110, '0);
      chk("R3 literal", reg_rdata, 96'hF8007FFFF000001FFEF81010);
      // R4/R5 clamp edges: lanes 800,FFF,000,0FF,100,7FF,080,001
      run_op(2'b10, '0, 96'h0010807FF1000FF000FFF800);
      chk("R4 literal", {32'd0, mem_wdata}, {32'd0, 64'h0180FFFFFF000000});
      run_op(2'b11, '0, 96'h0010807FF1000FF000FFF800);
      chk("R5 literal", {32'd0, mem_wdata}, {32'd0, 64'h017F7F7F7F00FF80});
      // R5 -128 and -129 both give 0x80, 127 passes
      run_op(2'b11, '0, 96'h07FF80F7F07F000000000000);
      chk("R5 low edge", {32'd0, mem_wdata}, {32'd0, 64'h7F80807F00000000});

      // R7: idle cycles with changing inputs leave outputs alone
      @(negedge clk);
      mem_rdata = 64'hFFFF0000FFFF0000; reg_wdata = 96'h800800800800800800800800; in_op = 2'b10;
      @(negedge clk);
      @(negedge clk);
      chk("R6 idle out_valid", {95'd0, out_valid}, 96'd0);
      chk("R7 idle reg_rdata", reg_rdata, exp_reg);
      chk("R7 idle mem_wdata", {32'd0, mem_wdata}, {32'd0, exp_mem});
      chk("R8 idle out_op", {94'd0, out_op}, {94'd0, exp_op});

      // R6: back-to-back requests each produce one valid cycle
      @(negedge clk);
      in_valid = 1'b1; in_op = 2'b00; mem_rdata = 64'h0102030405060708;
      @(negedge clk);
      in_op = 2'b10; reg_wdata = 96'h100100100100100100100100;
      chk("R6 back-to-back 1", reg_rdata, m_widen(64'h0102030405060708, 1'b0));
      @(negedge clk);
      in_valid = 1'b0;
      chk("R6 back-to-back 2", {32'd0, mem_wdata}, {32'd0, 64'hFFFFFFFFFFFFFFFF});
      chk("R6 back-to-back valid", {95'd0, out_valid}, 96'd1);
      @(negedge clk);
      chk("R6 valid drops", {95'd0, out_valid}, 96'd0);

      // R1: asynchronous reset mid-run clears everything
      rst_n = 1'b0;
      #1;
      chk("R1 mid-run reg_rdata", reg_rdata, 96'd0);
      chk("R1 mid-run mem_wdata", {32'd0, mem_wdata}, 96'd0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule